// File: doc/BRIEF.md
# Edge-Started Monostable Switch Debouncer with Mode Sequencer

This block cleans up a bouncing, active-low push button and turns clean presses into mode steps. The raw button line is first synchronized. Any change of its synchronized level, in either direction, starts a one-shot timer. The timer is clocked by strobes from a slow time base, which a prescaler divides further. If the line changes again before the timer expires, the count starts over from zero. Bouncing therefore only lengthens the wait and never produces an early result.

When the programmed period elapses with no further change, the block emits a single one-clock pulse. With the pulse it reports the level the line has settled to. A small sequencer watches these pulses. A debounced low level marks a press. A later debounced high level completes the cycle and moves the sequencer to the next of four computation modes. The current mode appears as a 2-bit code on two LED outputs.

A typical user ties `sw_n` to the button pin and `slow_tick` to a strobe from a low-frequency oscillator domain that has already been brought into `clk`. The user sets `period` to the debounce interval, measured in prescaled ticks.

Top module: `edge_mono_debounce`

## Requirements
- R1: After reset, `led_code` is 2'b00 (basic mode), `db_pulse` is 0 and `db_level` is 1.
- R2: A falling or a rising change on `sw_n` starts the timer. With `slow_tick` held high, `db_pulse` is high during the clock cycle that follows the (3 + PRESCALE*period + 1)-th rising clock edge after the change. That is the 10th edge for PRESCALE=2 and period=3.
- R3: A change of `sw_n` while the timer runs restarts the count at zero. The pulse then follows the last change with the latency of R2, and no pulse is produced for the earlier changes.
- R4: `db_pulse` is exactly one clock wide. With it, `db_level` shows the synchronized level of `sw_n`: 0 after a press and 1 after a release. `db_level` holds that value until the next pulse.
- R5: The count advances only on every PRESCALE-th cycle in which `slow_tick` is high. While `slow_tick` stays low, no pulse is produced however long the wait.
- R6: `led_code` steps once, in the clock cycle after a pulse with `db_level`=1, and only if a pulse with `db_level`=0 has occurred since the last step. A press pulse alone leaves `led_code` unchanged.
- R7: Mode codes on `led_code` are 00 basic, 01 average, 10 burst average, 11 low-pass. After 11 the next step returns to 00.
- R8: A short low glitch on `sw_n` that returns high before the timer expires yields one pulse with `db_level`=1 and no mode step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_n | input | 1 | Raw button line, low while pressed |
| slow_tick | input | 1 | One-cycle strobe from the slow time base |
| period | input | PW | Debounce interval in prescaled ticks (at least 1) |
| db_pulse | output | 1 | One-cycle pulse when the interval completes |
| db_level | output | 1 | Debounced level sampled at the pulse |
| led_code | output | 2 | Current computation mode code |

## Verification
Each change of `sw_n` goes through three flops: two for synchronization and one that holds the previous level for edge detection. The prescaled count follows, and then the pulse register. With `slow_tick` held high and PRESCALE=2, the pulse is therefore due after edge 4+2·period, counted from the first rising edge after the change, and `led_code` moves one edge later. Every directed task changes the input just after a falling edge and counts rising edges from that point. It samples one nanosecond after each rising edge and compares the edge on which the pulse appeared with the computed value. For restarts, the count is taken from the last change only. The gated-tick test checks the absence of any pulse across a long window and the mode code after the pulse.

// File: rtl/edge_mono_debounce.sv
module edge_mono_debounce #(
  parameter int PW       = 16,
  parameter int PRESCALE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_n,
  input  logic          slow_tick,
  input  logic [PW-1:0] period,
  output logic          db_pulse,
  output logic          db_level,
  output logic [1:0]    led_code
);

  localparam int PSW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PSW-1:0] PS_LAST = PSW'(PRESCALE - 1);

  logic sync_a, sync_b, sync_q;
  logic running;
  logic [PSW-1:0] pre;
  logic [PW-1:0]  cnt;
  logic pressed_seen;

  wire line_edge = sync_b ^ sync_q;
  wire scaled    = running && slow_tick && (pre == PS_LAST);
  wire expire    = running && (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= 1'b1;
      sync_b <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      sync_a <= sw_n;
      sync_b <= sync_a;
      sync_q <= sync_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      pre      <= '0;
      cnt      <= '0;
      db_pulse <= 1'b0;
      db_level <= 1'b1;
    end else begin
      db_pulse <= 1'b0;
      if (line_edge) begin
        running <= 1'b1;
        pre     <= '0;
        cnt     <= '0;
      end else if (expire) begin
        running  <= 1'b0;
        pre      <= '0;
        cnt      <= '0;
        db_pulse <= 1'b1;
        db_level <= sync_b;
      end else if (running && slow_tick) begin
        pre <= scaled ? '0 : pre + 1'b1;
        if (scaled) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_code     <= 2'b00;
      pressed_seen <= 1'b0;
    end else if (db_pulse) begin
      if (!db_level) begin
        pressed_seen <= 1'b1;
      end else if (pressed_seen) begin
        pressed_seen <= 1'b0;
        led_code     <= led_code + 2'b01;
      end
    end
  end

endmodule

// File: rtl/edge_mono_debounce_chk.sv
module edge_mono_debounce_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       db_pulse,
  input logic       db_level,
  input logic [1:0] led_code
);

  a_r4_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    db_pulse |=> !db_pulse);

  a_r4_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    !db_pulse |-> $stable(db_level));

  a_r6_mode_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !db_pulse |=> $stable(led_code));

  a_r6_press_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (db_pulse && !db_level) |=> $stable(led_code));

  a_r7_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (led_code != $past(led_code)) |-> (led_code == $past(led_code) + 2'b01));

endmodule

bind edge_mono_debounce edge_mono_debounce_chk chk_i (
  .clk(clk), .rst_n(rst_n), .db_pulse(db_pulse),
  .db_level(db_level), .led_code(led_code)
);

// File: tb/edge_mono_debounce_tb_top.sv
`timescale 1ns/1ps
module edge_mono_debounce_tb_top;
  localparam int PW = 16;
  localparam int P  = 3;
  localparam int LAT = 4 + 2 * P;

  logic clk = 1'b0, rst_n = 1'b0, sw_n = 1'b1, slow_tick = 1'b1;
  logic [PW-1:0] period = PW'(P);
  logic db_pulse, db_level;
  logic [1:0] led_code;
  int n_chk = 0, n_bad = 0;
  int tick_mode = 0;
  int tick_div = 0;

  always #2.5 clk = ~clk;

  edge_mono_debounce #(.PW(PW), .PRESCALE(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_n(sw_n), .slow_tick(slow_tick),
    .period(period), .db_pulse(db_pulse), .db_level(db_level), .led_code(led_code)
  );

  always @(negedge clk) begin
    tick_div <= (tick_div == 2) ? 0 : tick_div + 1;
    slow_tick <= (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? (tick_div == 0) : 1'b0;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(input int limit, output int k, output int lvl);
    k = -1; lvl = -1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #1;
      if (db_pulse && k < 0) begin k = i; lvl = db_level; end
    end
  endtask

  task automatic move_and_measure(input logic v, input string req, input int exp_lvl);
    int k, lvl;
    @(negedge clk); sw_n = v;
    wait_pulse(LAT + 2, k, lvl);
    check(req, k, LAT);
    check(req, lvl, exp_lvl);
  endtask

  task automatic t_reset;
    check("R1", led_code, 0);
    check("R1", db_pulse, 0);
    check("R1", db_level, 1);
  endtask

  task automatic t_press_release;
    move_and_measure(1'b0, "R2", 0);
    check("R6", led_code, 0);
    move_and_measure(1'b1, "R4", 1);
    @(negedge clk);
    check("R7", led_code, 1);
  endtask

  task automatic t_bounce;
    int k, lvl;
    @(negedge clk); sw_n = 1'b0;
    repeat (4) @(negedge clk);
    sw_n = 1'b1;
    repeat (3) @(negedge clk);
    sw_n = 1'b0;
    wait_pulse(LAT + 4, k, lvl);
    check("R3", k, LAT);
    check("R3", lvl, 0);
    move_and_measure(1'b1, "R3", 1);
    @(negedge clk);
    check("R7", led_code, 2);
  endtask

  task automatic t_glitch;
    int k, lvl;
    @(negedge clk); sw_n = 1'b0;
    repeat (3) @(negedge clk);
    sw_n = 1'b1;
    wait_pulse(LAT + 4, k, lvl);
    check("R8", k, LAT);
    check("R8", lvl, 1);
    @(negedge clk);
    check("R8", led_code, 2);
  endtask

  task automatic t_tick_gate;
    int k, lvl;
    tick_mode = 2;
    @(negedge clk); sw_n = 1'b0;
    wait_pulse(80, k, lvl);
    check("R5", k, -1);
    tick_mode = 0;
    wait_pulse(2 * P + 4, k, lvl);
    check("R5", lvl, 0);
    tick_mode = 1;
    @(negedge clk); sw_n = 1'b1;
    wait_pulse(LAT, k, lvl);
    check("R5", k, -1);
    wait_pulse(3 * 2 * P + 10, k, lvl);
    check("R5", lvl, 1);
    tick_mode = 0;
    @(negedge clk);
    check("R7", led_code, 3);
  endtask

  task automatic t_wrap;
    move_and_measure(1'b0, "R6", 0);
    move_and_measure(1'b1, "R6", 1);
    @(negedge clk);
    check("R7", led_code, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_press_release();
    t_bounce();
    t_glitch();
    t_tick_gate();
    t_wrap();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule